// File: doc/BRIEF.md
# Floating-Point EX-1 Operand Forwarding Unit

This block chooses the two 64-bit operands of a floating-point add, subtract or multiply as it enters the first of the three execution stages of a pipelined FP unit. Each operand comes from one of five places:

- the value read from the FP register file;
- the finished result leaving EX-3;
- the M1, M2 or RW pipeline registers.

The unit picks the source by comparing the operand's register number with the destination numbers of the older FP instructions ahead of it.

A result exists only once EX-3 is complete. An older instruction that is still in EX-1 or EX-2 can therefore never feed an operand. When an operand depends on such an instruction, the unit raises a not-ready flag, and a separate stall unit acts on that flag. There are 32 FP registers, and register F0 is an ordinary register with no special treatment. The unit is purely combinational.

Top module: `fpfwd_ex1`

## Requirements
- R1: When no write-enabled destination in EX-3, M1, M2 or RW equals an operand's register number, that operand's select is 0 and the operand equals the register-file value.
- R2: When only the EX-3 stage matches, the select is 1 and the operand equals the EX-3 result.
- R3: When the M1 stage is the youngest match, the select is 2 and the operand equals the M1 value.
- R4: When the M2 stage is the youngest match, the select is 3 and the operand equals the M2 value.
- R5: When the RW stage is the only match, the select is 4 and the operand equals the RW value.
- R6: When several stages match, the youngest one wins, in the order EX-3, then M1, then M2, then RW.
- R7: A stage counts as a match only while its FP write enable is 1. A matching number with the enable at 0 has no effect on the select, the operand or the flag.
- R8: Register number 0 is forwarded exactly like any other register.
- R9: not_ready is 1 exactly when at least one operand equals a write-enabled destination held in EX-1 or EX-2.
- R10: The two operands are resolved independently. When both name the same register, they get the same select and the same value.
- R11: A match in EX-1 or EX-2 is never chosen as a source. The select and the operand are formed from EX-3, M1, M2, RW and the register file only, even while not_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_a | input | 5 | FP register number of operand A |
| rs_b | input | 5 | FP register number of operand B |
| rf_a | input | 64 | Register-file value for operand A |
| rf_b | input | 64 | Register-file value for operand B |
| ex1_we | input | 1 | FP write enable of the instruction in EX-1 |
| ex1_rd | input | 5 | Destination of the instruction in EX-1 |
| ex2_we | input | 1 | FP write enable of the instruction in EX-2 |
| ex2_rd | input | 5 | Destination of the instruction in EX-2 |
| ex3_we | input | 1 | FP write enable of the instruction in EX-3 |
| ex3_rd | input | 5 | Destination of the instruction in EX-3 |
| ex3_res | input | 64 | Completed EX-3 result |
| m1_we | input | 1 | FP write enable held in the M1 register |
| m1_rd | input | 5 | Destination held in the M1 register |
| m1_data | input | 64 | Result held in the M1 register |
| m2_we | input | 1 | FP write enable held in the M2 register |
| m2_rd | input | 5 | Destination held in the M2 register |
| m2_data | input | 64 | Result held in the M2 register |
| rw_we | input | 1 | FP write enable held in the RW register |
| rw_rd | input | 5 | Destination held in the RW register |
| rw_data | input | 64 | Result held in the RW register |
| sel_a | output | 3 | Source of operand A (0 register file, 1 EX-3, 2 M1, 3 M2, 4 RW) |
| sel_b | output | 3 | Source of operand B, with the same encoding |
| opnd_a | output | 64 | Forwarded operand A |
| opnd_b | output | 64 | Forwarded operand B |
| not_ready | output | 1 | An operand depends on an instruction still in EX-1 or EX-2 |

## Verification
No register lies between any input and any output, so every select, operand and flag is due in the same cycle that the stimulus is applied. The bench changes the inputs just after a rising edge and compares at the following falling edge. Half a clock period has then passed with no edge in between, so each comparison sees the response to exactly one input pattern.

The sweep steps through every combination of write enables over the six stages. For each combination it tries every way of pointing each stage's destination at operand A, at operand B or at an unrelated register. It also rotates the operand numbers so that F0 and equal operands both occur. Directed cases then isolate priority, the write-enable gating and the EX-1/EX-2 exclusion.

// File: rtl/fpfwd_pkg.sv
package fpfwd_pkg;
  localparam int FWD_STAGES  = 4;  // EX-3, M1, M2, RW, youngest first
  localparam int BUSY_STAGES = 2;  // EX-1, EX-2: results not yet valid
  localparam int SEL_W       = $clog2(FWD_STAGES + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_RF  = 3'd0,
    SRC_EX3 = 3'd1,
    SRC_M1  = 3'd2,
    SRC_M2  = 3'd3,
    SRC_RW  = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fpfwd_tag_cmp.sv
module fpfwd_tag_cmp #(
  parameter int TAG_W   = 5,
  parameter int NUM_TAG = 4
) (
  input  logic [NUM_TAG-1:0]            we,
  input  logic [NUM_TAG-1:0][TAG_W-1:0] rd,
  input  logic [TAG_W-1:0]              rs,
  output logic [NUM_TAG-1:0]            hit
);
  // one comparator per older stage; register 0 has no special case
  for (genvar i = 0; i < NUM_TAG; i++) begin : g_cmp
    assign hit[i] = we[i] & (rd[i] == rs);
  end
endmodule

// File: rtl/fpfwd_pick.sv
module fpfwd_pick #(
  parameter int NUM_FWD = 4,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_FWD-1:0] hit,
  output logic [SEL_W-1:0]   sel
);
  // bit 0 is the youngest source; scanning oldest-first lets it win last
  always_comb begin
    sel = '0;
    for (int i = NUM_FWD - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/fpfwd_opnd_mux.sv
module fpfwd_opnd_mux #(
  parameter int DATA_W  = 64,
  parameter int NUM_FWD = 4,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0]               sel,
  input  logic [DATA_W-1:0]              rf,
  input  logic [NUM_FWD-1:0][DATA_W-1:0] fwd,
  output logic [DATA_W-1:0]              out
);
  always_comb begin
    out = rf;
    for (int i = 0; i < NUM_FWD; i++) begin
      if (sel == SEL_W'(i + 1)) out = fwd[i];
    end
  end
endmodule

// File: rtl/fpfwd_ex1.sv
module fpfwd_ex1
  import fpfwd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 5
) (
  input  logic [TAG_W-1:0]  rs_a,
  input  logic [TAG_W-1:0]  rs_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic              ex1_we,
  input  logic [TAG_W-1:0]  ex1_rd,
  input  logic              ex2_we,
  input  logic [TAG_W-1:0]  ex2_rd,
  input  logic              ex3_we,
  input  logic [TAG_W-1:0]  ex3_rd,
  input  logic [DATA_W-1:0] ex3_res,
  input  logic              m1_we,
  input  logic [TAG_W-1:0]  m1_rd,
  input  logic [DATA_W-1:0] m1_data,
  input  logic              m2_we,
  input  logic [TAG_W-1:0]  m2_rd,
  input  logic [DATA_W-1:0] m2_data,
  input  logic              rw_we,
  input  logic [TAG_W-1:0]  rw_rd,
  input  logic [DATA_W-1:0] rw_data,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              not_ready
);
  localparam int NUM_OPS = 2;

  // forwarding sources, index 0 youngest
  logic [FWD_STAGES-1:0]             fwd_we;
  logic [FWD_STAGES-1:0][TAG_W-1:0]  fwd_rd;
  logic [FWD_STAGES-1:0][DATA_W-1:0] fwd_data;
  // stages whose result is still partial
  logic [BUSY_STAGES-1:0]            busy_we;
  logic [BUSY_STAGES-1:0][TAG_W-1:0] busy_rd;

  logic [NUM_OPS-1:0][TAG_W-1:0]       rs_op;
  logic [NUM_OPS-1:0][DATA_W-1:0]      rf_op;
  logic [NUM_OPS-1:0][SEL_W-1:0]       sel_op;
  logic [NUM_OPS-1:0][DATA_W-1:0]      opnd_op;
  logic [NUM_OPS-1:0][FWD_STAGES-1:0]  fwd_hit;
  logic [NUM_OPS-1:0][BUSY_STAGES-1:0] busy_hit;

  assign fwd_we   = {rw_we, m2_we, m1_we, ex3_we};
  assign fwd_rd   = {rw_rd, m2_rd, m1_rd, ex3_rd};
  assign fwd_data = {rw_data, m2_data, m1_data, ex3_res};
  assign busy_we  = {ex2_we, ex1_we};
  assign busy_rd  = {ex2_rd, ex1_rd};

  assign rs_op = {rs_b, rs_a};
  assign rf_op = {rf_b, rf_a};

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    fpfwd_tag_cmp #(.TAG_W(TAG_W), .NUM_TAG(FWD_STAGES)) u_fwd_cmp (
      .we (fwd_we),
      .rd (fwd_rd),
      .rs (rs_op[k]),
      .hit(fwd_hit[k])
    );

    fpfwd_tag_cmp #(.TAG_W(TAG_W), .NUM_TAG(BUSY_STAGES)) u_busy_cmp (
      .we (busy_we),
      .rd (busy_rd),
      .rs (rs_op[k]),
      .hit(busy_hit[k])
    );

    fpfwd_pick #(.NUM_FWD(FWD_STAGES), .SEL_W(SEL_W)) u_pick (
      .hit(fwd_hit[k]),
      .sel(sel_op[k])
    );

    fpfwd_opnd_mux #(.DATA_W(DATA_W), .NUM_FWD(FWD_STAGES), .SEL_W(SEL_W)) u_mux (
      .sel(sel_op[k]),
      .rf (rf_op[k]),
      .fwd(fwd_data),
      .out(opnd_op[k])
    );
  end

  assign sel_a     = sel_op[0];
  assign sel_b     = sel_op[1];
  assign opnd_a    = opnd_op[0];
  assign opnd_b    = opnd_op[1];
  assign not_ready = |busy_hit;

  // cross-checks between tag compare, priority pick, mux and flag
  always_comb begin : chk
    for (int k = 0; k < NUM_OPS; k++) begin
      assert_sel_range_R11: assert (sel_op[k] <= SEL_W'(FWD_STAGES))
        else $error("select out of range");
      if (sel_op[k] == SEL_W'(SRC_RF)) begin
        assert_rf_value_R1: assert (opnd_op[k] == rf_op[k])
          else $error("register-file operand corrupted");
        for (int i = 0; i < FWD_STAGES; i++) begin
          assert_rf_nomatch_R1: assert (!(fwd_we[i] && fwd_rd[i] == rs_op[k]))
            else $error("match ignored");
        end
      end
      for (int i = 0; i < FWD_STAGES; i++) begin
        if (sel_op[k] == SEL_W'(i + 1)) begin
          assert_src_enabled_R7: assert (fwd_we[i] && fwd_rd[i] == rs_op[k])
            else $error("forwarded from a non-matching stage");
          assert_fwd_value_R2: assert (opnd_op[k] == fwd_data[i])
            else $error("forwarded value differs from source");
          for (int j = 0; j < i; j++) begin
            assert_youngest_R6: assert (!(fwd_we[j] && fwd_rd[j] == rs_op[k]))
              else $error("older source chosen over younger");
          end
        end
      end
      for (int b = 0; b < BUSY_STAGES; b++) begin
        if (busy_we[b] && busy_rd[b] == rs_op[k]) begin
          assert_partial_flag_R9: assert (not_ready)
            else $error("partial-result dependency not flagged");
        end
      end
    end
  end
endmodule

// File: tb/sim_fpfwd_ex1.sv
module sim_fpfwd_ex1;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rs_a, rs_b;
  logic [63:0] rf_a, rf_b;
  logic        ex1_we, ex2_we, ex3_we, m1_we, m2_we, rw_we;
  logic [4:0]  ex1_rd, ex2_rd, ex3_rd, m1_rd, m2_rd, rw_rd;
  logic [63:0] ex3_res, m1_data, m2_data, rw_data;
  logic [2:0]  sel_a, sel_b;
  logic [63:0] opnd_a, opnd_b;
  logic        not_ready;

  fpfwd_ex1 u0 (
    .rs_a(rs_a), .rs_b(rs_b), .rf_a(rf_a), .rf_b(rf_b),
    .ex1_we(ex1_we), .ex1_rd(ex1_rd), .ex2_we(ex2_we), .ex2_rd(ex2_rd),
    .ex3_we(ex3_we), .ex3_rd(ex3_rd), .ex3_res(ex3_res),
    .m1_we(m1_we), .m1_rd(m1_rd), .m1_data(m1_data),
    .m2_we(m2_we), .m2_rd(m2_rd), .m2_data(m2_data),
    .rw_we(rw_we), .rw_rd(rw_rd), .rw_data(rw_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .not_ready(not_ready)
  );

  // stage index: 0 EX-1, 1 EX-2, 2 EX-3, 3 M1, 4 M2, 5 RW
  logic        we6 [6];
  logic [4:0]  rd6 [6];
  logic [63:0] dat [4];   // EX-3, M1, M2, RW
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply();
    ex1_we = we6[0]; ex1_rd = rd6[0];
    ex2_we = we6[1]; ex2_rd = rd6[1];
    ex3_we = we6[2]; ex3_rd = rd6[2]; ex3_res = dat[0];
    m1_we  = we6[3]; m1_rd  = rd6[3]; m1_data = dat[1];
    m2_we  = we6[4]; m2_rd  = rd6[4]; m2_data = dat[2];
    rw_we  = we6[5]; rw_rd  = rd6[5]; rw_data = dat[3];
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_sel(input logic [4:0] rs);
    logic [2:0] s = 3'd0;
    for (int i = 3; i >= 0; i--)
      if (we6[i+2] && rd6[i+2] == rs) s = 3'(i + 1);
    return s;
  endfunction

  function automatic logic [63:0] exp_val(input logic [2:0] s, input logic [63:0] rf);
    return (s == 3'd0) ? rf : dat[s-1];
  endfunction

  function automatic logic exp_nr();
    logic r = 1'b0;
    for (int i = 0; i < 2; i++)
      if (we6[i] && (rd6[i] == rs_a || rd6[i] == rs_b)) r = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_all(input string ctx);
    logic [2:0] ea = exp_sel(rs_a);
    logic [2:0] eb = exp_sel(rs_b);
    chk({tag_of(ea), " sel_a ", ctx}, 64'(sel_a), 64'(ea));
    chk({tag_of(eb), " sel_b ", ctx}, 64'(sel_b), 64'(eb));
    chk({tag_of(ea), " opnd_a ", ctx}, opnd_a, exp_val(ea, rf_a));
    chk({tag_of(eb), " opnd_b ", ctx}, opnd_b, exp_val(eb, rf_b));
    chk({"R9 not_ready ", ctx}, 64'(not_ready), 64'(exp_nr()));
  endtask

  task automatic clear_stages();
    for (int i = 0; i < 6; i++) begin we6[i] = 1'b0; rd6[i] = 5'd31; end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) dat[i] = {32'hD00D_0000 + 32'(i), 32'h1234_5678};
    rf_a = 64'hAAAA_0000_0000_0001;
    rf_b = 64'hBBBB_0000_0000_0002;
    rs_a = 5'd3; rs_b = 5'd4;
    clear_stages();
    @(posedge clk); #1;
    apply();
    // idle: nothing in flight
    check_all("idle");
    chk("R1 idle operand from register file", opnd_a, rf_a);

    // R8: F0 forwarded from M2
    @(posedge clk); #1;
    clear_stages(); rs_a = 5'd0; we6[4] = 1'b1; rd6[4] = 5'd0;
    apply();
    chk("R8 F0 select", 64'(sel_a), 64'd3);
    chk("R8 F0 value", opnd_a, dat[2]);

    // R6: all four later stages match, EX-3 wins; then M1 once EX-3 disabled (R7)
    @(posedge clk); #1;
    clear_stages(); rs_a = 5'd9;
    for (int i = 2; i < 6; i++) begin we6[i] = 1'b1; rd6[i] = 5'd9; end
    apply();
    chk("R6 youngest EX-3", 64'(sel_a), 64'd1);
    @(posedge clk); #1;
    we6[2] = 1'b0;
    apply();
    chk("R6 R7 disabled EX-3 skipped", 64'(sel_a), 64'd2);
    chk("R6 value from M1", opnd_a, dat[1]);

    // R11: EX-1 matches too, RW is the only finished source
    @(posedge clk); #1;
    clear_stages(); rs_a = 5'd9; rs_b = 5'd4;
    we6[0] = 1'b1; rd6[0] = 5'd9; we6[5] = 1'b1; rd6[5] = 5'd9;
    apply();
    chk("R11 select skips EX-1", 64'(sel_a), 64'd4);
    chk("R11 value from RW", opnd_a, dat[3]);
    chk("R9 flag with EX-1 match", 64'(not_ready), 64'd1);

    // R10: both operands name the same register
    @(posedge clk); #1;
    clear_stages(); rs_a = 5'd12; rs_b = 5'd12; we6[3] = 1'b1; rd6[3] = 5'd12;
    apply();
    chk("R10 sel_a", 64'(sel_a), 64'd2);
    chk("R10 sel_b", 64'(sel_b), 64'd2);
    chk("R10 same value", opnd_b, opnd_a);

    // R7: all destinations match but no write enables
    @(posedge clk); #1;
    clear_stages(); rs_a = 5'd7; rs_b = 5'd7;
    for (int i = 0; i < 6; i++) rd6[i] = 5'd7;
    apply();
    chk("R7 no enable select", 64'(sel_a), 64'd0);
    chk("R7 no enable operand", opnd_a, rf_a);
    chk("R7 no enable flag", 64'(not_ready), 64'd0);

    // sweep: all enable masks x per-stage destination choice (A, B, other)
    for (int n = 0; n < 64 * 729; n++) begin
      int pat = n / 64;
      logic [4:0] oth;
      @(posedge clk); #1;
      rs_a = 5'((n * 7) % 32);
      rs_b = (n % 5 == 0) ? rs_a : 5'((n * 7 + 3) % 32);
      oth  = 5'((n * 7 + 11) % 32);
      rf_a = {32'hF1F1_0000, 32'(n)};
      rf_b = {32'hF2F2_0000, 32'(n)};
      for (int i = 0; i < 4; i++) dat[i] = {8'hC0 + 8'(i), 24'(n), 32'h0BAD_0000 + 32'(i)};
      for (int s = 0; s < 6; s++) begin
        int d = pat % 3;
        pat = pat / 3;
        we6[s] = n[s];
        rd6[s] = (d == 0) ? rs_a : (d == 1) ? rs_b : oth;
      end
      apply();
      check_all("sweep");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule